// File: doc/BRIEF.md
# Conversion Result Capture and Host Read Bridge

This block sits between a 12-bit sampling converter and a host bus. The converter's own select and read lines are tied active, so its data lines always carry the latest result. The bridge watches the converter's busy line and latches the data on busy's rising edge, the instant that marks the end of a conversion. It raises an interrupt request for each new sample and flags an overrun when a new sample replaces one that was never read.

The host reads the stored result through a chip select and a read strobe. A mode input picks between two presentations. In word mode one 16-bit read returns the result left-justified, with four zero bits at the bottom. In byte mode two 8-bit reads are needed. The first returns the upper eight result bits. The end of that first read copies the low four bits into a separate nibble latch, and the second read returns them. The bus is modelled as high impedance by two output enables, one for the upper byte path and one for the nibble path. Both are low whenever no read is active.

All inputs are sampled in the system clock domain. Edges on busy and on the combined read strobe are detected one clock after the change.

Top module: `cnv_result_bridge`

## Requirements
- R1: After reset, irq and overrun are 0, both output enables are 0 and bus_data is 0.
- R2: On the first clock after cnv_busy rises, the block stores the cnv_data value present at that clock. Later changes of cnv_data while busy stays high do not alter the stored result.
- R3: In word mode (byte_mode=0), an active read (host_cs_n=0 and host_rd_n=0) drives bus_data = {result[11:0], 4'b0000}, with bus_oe_hi=1 and bus_oe_lo=1.
- R4: In byte mode (byte_mode=1), the first read of a sample drives bus_data = {8'h00, result[11:4]}, with only bus_oe_hi asserted.
- R5: In byte mode, the end of the first read (the combined strobe host_cs_n|host_rd_n returning high) copies result[3:0] into the nibble latch. The next read drives bus_data = {12'h000, nibble}, with only bus_oe_lo asserted. After that second read, the pointer returns to the high byte.
- R6: While no read is active, bus_oe_hi=0, bus_oe_lo=0 and bus_data=0.
- R7: irq goes to 1 on the clock after a capture. It returns to 0 at the end of the first read of that sample: a word read or a high-byte read. A second byte read leaves irq unchanged.
- R8: A capture arriving while the previous sample is still unread sets overrun. overrun stays set until the end of the next first read, which clears it. A capture after the previous sample was read leaves overrun at 0.
- R9: A capture always returns the byte pointer to the high byte. When a capture and the end of a first read occur on the same clock, the capture wins: irq stays 1 and the next read returns the new high byte. Because the old sample counts as read, overrun is 0.
- R10: While byte_mode is 0, the byte pointer is held at the high byte. Switching to word mode after a lone high-byte read therefore makes the next read a full word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_busy | input | 1 | Converter busy line; the rising edge marks a finished conversion |
| cnv_data | input | 12 | Converter result lines |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| byte_mode | input | 1 | 0 selects word reads, 1 selects two byte reads |
| bus_data | output | 16 | Read data (0 when not driven) |
| bus_oe_hi | output | 1 | Output enable for the upper byte path |
| bus_oe_lo | output | 1 | Output enable for the nibble path |
| irq | output | 1 | New-sample interrupt request |
| overrun | output | 1 | An unread sample was overwritten |

## Verification
The hardest case to reach is a capture landing on the same clock as the end of a high-byte read. The two rules pull the pointer, irq and overrun in opposite directions there. The stimulus lowers busy before the read begins. It then raises busy on the same clock phase that releases the read strobe, so both edges are detected at one clock edge. The next read must then return the new sample's high byte. A second corner is a capture that arrives between the two byte reads. The bench checks that this capture drops the stale nibble and restarts the byte order.

// File: rtl/cnv_bridge_pkg.sv
package cnv_bridge_pkg;

    typedef enum logic {
        SEL_HI = 1'b0,
        SEL_LO = 1'b1
    } byte_sel_e;

endpackage

// File: rtl/cnv_edge_det.sv
module cnv_edge_det #(
    parameter bit RISE = 1'b1,
    parameter bit IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sig_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sig_i & prev_q;
        end
    endgenerate

endmodule

// File: rtl/cnv_read_seq.sv
module cnv_read_seq
    import cnv_bridge_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic [RES_W-1:0]   data_i,
    input  logic               rd_end_i,
    input  logic               byte_mode_i,
    output logic [RES_W-1:0]   res_o,
    output logic [RES_W-BYTE_W-1:0] nib_o,
    output byte_sel_e          sel_o,
    output logic               irq_o,
    output logic               ovr_o
);
    localparam int NIB_W = RES_W - BYTE_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [NIB_W-1:0] nib;
        byte_sel_e        sel;
        logic             irq;
        logic             unread;
        logic             ovr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    first_end;

    always_comb begin
        st_d      = st_q;
        first_end = rd_end_i && (st_q.sel == SEL_HI);
        if (first_end) begin
            st_d.irq    = 1'b0;
            st_d.unread = 1'b0;
            st_d.ovr    = 1'b0;
            if (byte_mode_i) begin
                st_d.nib = st_q.res[NIB_W-1:0];
                st_d.sel = SEL_LO;
            end
        end else if (rd_end_i) begin
            st_d.sel = SEL_HI;
        end
        if (!byte_mode_i) begin
            st_d.sel = SEL_HI;
        end
        if (cap_i) begin
            st_d.res    = data_i;
            st_d.irq    = 1'b1;
            st_d.unread = 1'b1;
            st_d.sel    = SEL_HI;
            if (st_q.unread && !first_end) begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;
    assign nib_o = st_q.nib;
    assign sel_o = st_q.sel;
    assign irq_o = st_q.irq;
    assign ovr_o = st_q.ovr;

    // R2: stored result follows the data present at the capture clock
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (res_o == $past(data_i)));

    // R7: a capture raises the interrupt request on the next clock
    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> irq_o);

    // R8: overwrite of an unread sample flags overrun
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && st_q.unread && !rd_end_i) |=> ovr_o);

    // R5: end of the high-byte read copies the low nibble
    p_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end_i && byte_mode_i && !cap_i && sel_o == SEL_HI)
        |=> (nib_o == $past(res_o[NIB_W-1:0]) && sel_o == SEL_LO));

    // R9: a capture returns the pointer to the high byte
    p_capture_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (sel_o == SEL_HI));

    // R10: word mode keeps the pointer at the high byte
    p_word_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_mode_i |=> (sel_o == SEL_HI));

endmodule

// File: rtl/cnv_bus_mux.sv
module cnv_bus_mux
    import cnv_bridge_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_act_i,
    input  logic                    byte_mode_i,
    input  byte_sel_e               sel_i,
    input  logic [RES_W-1:0]        res_i,
    input  logic [RES_W-BYTE_W-1:0] nib_i,
    output logic [BUS_W-1:0]        bus_o,
    output logic                    oe_hi_o,
    output logic                    oe_lo_o
);
    localparam int NIB_W = RES_W - BYTE_W;
    localparam int PAD_W = BUS_W - RES_W;

    always_comb begin
        oe_hi_o = 1'b0;
        oe_lo_o = 1'b0;
        bus_o   = '0;
        if (rd_act_i) begin
            if (!byte_mode_i) begin
                oe_hi_o = 1'b1;
                oe_lo_o = 1'b1;
                bus_o   = {res_i, {PAD_W{1'b0}}};
            end else if (sel_i == SEL_HI) begin
                oe_hi_o = 1'b1;
                bus_o   = {{(BUS_W-BYTE_W){1'b0}}, res_i[RES_W-1 -: BYTE_W]};
            end else begin
                oe_lo_o = 1'b1;
                bus_o   = {{(BUS_W-NIB_W){1'b0}}, nib_i};
            end
        end
    end

    // R6: nothing is driven while no read is active
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act_i |-> (!oe_hi_o && !oe_lo_o && bus_o == '0));

    // R4: in byte mode the two enables are never asserted together
    p_byte_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode_i |-> !(oe_hi_o && oe_lo_o));

endmodule

// File: rtl/cnv_result_bridge.sv
module cnv_result_bridge
    import cnv_bridge_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv_busy,
    input  logic [RES_W-1:0] cnv_data,
    input  logic             host_cs_n,
    input  logic             host_rd_n,
    input  logic             byte_mode,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_oe_hi,
    output logic             bus_oe_lo,
    output logic             irq,
    output logic             overrun
);
    localparam int NIB_W = RES_W - BYTE_W;

    logic             rd_act;
    logic             strobe_n;
    logic             cap;
    logic             rd_end;
    logic [RES_W-1:0] res;
    logic [NIB_W-1:0] nib;
    byte_sel_e        sel;

    assign rd_act   = ~host_cs_n & ~host_rd_n;
    assign strobe_n = host_cs_n | host_rd_n;

    cnv_edge_det #(.RISE(1'b1), .IDLE(1'b1)) u_busy_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (cnv_busy),
        .edge_o (cap)
    );

    cnv_edge_det #(.RISE(1'b1), .IDLE(1'b1)) u_strobe_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (strobe_n),
        .edge_o (rd_end)
    );

    cnv_read_seq #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap),
        .data_i      (cnv_data),
        .rd_end_i    (rd_end),
        .byte_mode_i (byte_mode),
        .res_o       (res),
        .nib_o       (nib),
        .sel_o       (sel),
        .irq_o       (irq),
        .ovr_o       (overrun)
    );

    cnv_bus_mux #(.RES_W(RES_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_act_i    (rd_act),
        .byte_mode_i (byte_mode),
        .sel_i       (sel),
        .res_i       (res),
        .nib_i       (nib),
        .bus_o       (bus_data),
        .oe_hi_o     (bus_oe_hi),
        .oe_lo_o     (bus_oe_lo)
    );

    // R3: a word-mode read enables both paths
    p_word_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !byte_mode) |-> (bus_oe_hi && bus_oe_lo));

endmodule

// File: tb/cnv_result_bridge_test.sv
module cnv_result_bridge_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_busy = 1'b1;
    logic [11:0] cnv_data = '0;
    logic        host_cs_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        byte_mode = 1'b0;
    logic [15:0] bus_data;
    logic        bus_oe_hi, bus_oe_lo, irq, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cnv_result_bridge uut (
        .clk(clk), .rst_n(rst_n), .cnv_busy(cnv_busy), .cnv_data(cnv_data),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .byte_mode(byte_mode),
        .bus_data(bus_data), .bus_oe_hi(bus_oe_hi), .bus_oe_lo(bus_oe_lo),
        .irq(irq), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [11:0] d);
        @(negedge clk); cnv_busy = 1'b0; cnv_data = d;
        @(negedge clk); cnv_busy = 1'b1;
        @(negedge clk); cnv_data = ~d;
    endtask

    task automatic do_read(output logic [15:0] b, output logic oh, output logic ol);
        @(negedge clk); host_cs_n = 1'b0; host_rd_n = 1'b0;
        @(negedge clk); b = bus_data; oh = bus_oe_hi; ol = bus_oe_lo;
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 overrun", {31'b0, overrun}, 0);
        check("R1 oe", {30'b0, bus_oe_hi, bus_oe_lo}, 0);
        check("R6 idle bus", {16'b0, bus_data}, 0);
    endtask

    task automatic t_word;
        logic [15:0] b; logic oh, ol;
        byte_mode = 1'b0;
        convert(12'hA5C);
        check("R7 irq set", {31'b0, irq}, 1);
        check("R6 idle after capture", {14'b0, bus_oe_hi, bus_oe_lo}, 0);
        do_read(b, oh, ol);
        check("R3 R2 word data", {16'b0, b}, 32'hA5C0);
        check("R3 word oe", {30'b0, oh, ol}, 32'h3);
        check("R7 irq cleared", {31'b0, irq}, 0);
    endtask

    task automatic t_byte;
        logic [15:0] b; logic oh, ol;
        byte_mode = 1'b1;
        convert(12'h3E7);
        do_read(b, oh, ol);
        check("R4 high byte", {16'b0, b}, 32'h003E);
        check("R4 oe", {30'b0, oh, ol}, 32'h2);
        check("R7 irq cleared by high byte", {31'b0, irq}, 0);
        do_read(b, oh, ol);
        check("R5 nibble", {16'b0, b}, 32'h0007);
        check("R5 oe", {30'b0, oh, ol}, 32'h1);
        check("R7 irq after second read", {31'b0, irq}, 0);
        do_read(b, oh, ol);
        check("R5 pointer back to high", {16'b0, b}, 32'h003E);
        do_read(b, oh, ol);
    endtask

    task automatic t_overrun;
        logic [15:0] b; logic oh, ol;
        byte_mode = 1'b0;
        convert(12'h111);
        check("R8 no overrun on first", {31'b0, overrun}, 0);
        convert(12'h222);
        check("R8 overrun set", {31'b0, overrun}, 1);
        do_read(b, oh, ol);
        check("R8 newest data", {16'b0, b}, 32'h2220);
        check("R8 overrun cleared", {31'b0, overrun}, 0);
    endtask

    task automatic t_ptr_reset;
        logic [15:0] b; logic oh, ol;
        byte_mode = 1'b1;
        convert(12'h9B4);
        do_read(b, oh, ol);
        check("R4 high byte 9B", {16'b0, b}, 32'h009B);
        convert(12'h6D2);
        check("R8 read sample no overrun", {31'b0, overrun}, 0);
        do_read(b, oh, ol);
        check("R9 capture restarts at high", {16'b0, b}, 32'h006D);
        check("R9 oe high path", {30'b0, oh, ol}, 32'h2);
        do_read(b, oh, ol);
        check("R9 new nibble", {16'b0, b}, 32'h0002);
    endtask

    task automatic t_collide;
        logic [15:0] b; logic oh, ol;
        byte_mode = 1'b1;
        convert(12'hC81);
        @(negedge clk); cnv_busy = 1'b0; cnv_data = 12'h5F3;
        @(negedge clk); host_cs_n = 1'b0; host_rd_n = 1'b0;
        @(negedge clk);
        check("R9 old high byte", {16'b0, bus_data}, 32'h00C8);
        host_cs_n = 1'b1; host_rd_n = 1'b1; cnv_busy = 1'b1;
        @(negedge clk);
        check("R9 irq held on collision", {31'b0, irq}, 1);
        check("R9 overrun clear on collision", {31'b0, overrun}, 0);
        do_read(b, oh, ol);
        check("R9 new high byte", {16'b0, b}, 32'h005F);
        do_read(b, oh, ol);
    endtask

    task automatic t_mode_switch;
        logic [15:0] b; logic oh, ol;
        byte_mode = 1'b1;
        convert(12'h4A9);
        do_read(b, oh, ol);
        check("R4 high byte 4A", {16'b0, b}, 32'h004A);
        byte_mode = 1'b0;
        @(negedge clk);
        do_read(b, oh, ol);
        check("R10 word after switch", {16'b0, b}, 32'h4A90);
        check("R10 word oe", {30'b0, oh, ol}, 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_byte();
        t_overrun();
        t_ptr_reset();
        t_collide();
        t_mode_switch();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule